// File: doc/BRIEF.md
# Ordered-Entry Combination Lock

This block is a clocked state machine that unlocks only when three dial operations arrive in one fixed order. An operation is a turn direction and a dial number. It is offered on a small input bus and qualified by a one-cycle valid strobe. Three parameters fix the secret steps. The lock keeps a two-bit progress code that records how many leading steps of the secret have been matched so far. An entry that does not continue the secret discards that progress.

Software or a front-end controller presents one operation per strobe. The block reports its progress code and a registered unlock flag. A relock input and a synchronous reset both return the lock to the locked idle state. Turning the dial, filtering contact bounce and driving any display are handled outside the block.

Top module: `combo_lock_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is idle. Idle means progress code 2'b00 with `unlocked` low. This holds whatever the other inputs are.
- R2: A cycle with `op_valid` low and `relock` low leaves the progress code and `unlocked` unchanged.
- R3: The direction bit is 0 for a right turn and 1 for a left turn. The progress codes are 00 (idle), 01 (first step matched), 10 (first two steps matched) and 11 (open). With default parameters, a valid right-13 in 00 moves the lock to 01. A valid left-22 in 01 then moves it to 10.
- R4: With default parameters, a valid right-3 in code 10 moves the lock to 11. `unlocked` is high from the clock edge that accepts this operation.
- R5: In codes 00, 01 and 10, a valid operation that is not the next secret step sends the lock to 00. If that operation equals the first secret step, the lock goes to 01 instead.
- R6: The three correct operations entered in any other order do not reach code 11.
- R7: In code 11, valid operations of any value leave the lock in 11 with `unlocked` high.
- R8: `relock` high at a rising edge sends the lock to 00 from any code. It takes priority over a simultaneous valid operation.
- R9: `unlocked` is high exactly when the progress code is 11.
- R10: The direction is part of the match. An operation with the right number but the wrong direction counts as a wrong step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| relock | input | 1 | Synchronous return to idle, active high |
| op_valid | input | 1 | One-cycle strobe qualifying an operation |
| op_dir | input | 1 | Turn direction: 0 right, 1 left |
| op_num | input | NUM_W (6) | Dial number of the operation |
| progress | output | 2 | Registered progress code |
| unlocked | output | 1 | High only in the open code |

## Verification
Every result here is due one clock edge after the stimulus: the progress code and `unlocked` both come straight from the state register. The bench drives each operation on a falling edge and waits through the next rising edge. It then samples both outputs at the following falling edge, so every sample sees exactly one state update. The clocked properties follow the same single-edge latency. They use `|=>` or a one-cycle `$past` and never look further back.

// File: rtl/lock_pkg.sv
package lock_pkg;

  typedef enum logic [1:0] {
    LK_IDLE = 2'b00,
    LK_ONE  = 2'b01,
    LK_TWO  = 2'b10,
    LK_OPEN = 2'b11
  } lock_state_e;

  // Next progress code from the current code and the per-step match flags.
  // hit[k] is high when the presented operation equals secret step k.
  function automatic lock_state_e lock_advance(
    input lock_state_e cur,
    input logic        valid,
    input logic        relock,
    input logic [2:0]  hit
  );
    lock_state_e nxt;
    nxt = cur;
    if (relock) begin
      nxt = LK_IDLE;
    end else if (valid) begin
      unique case (cur)
        LK_IDLE: nxt = hit[0] ? LK_ONE : LK_IDLE;
        LK_ONE:  nxt = hit[1] ? LK_TWO  : (hit[0] ? LK_ONE : LK_IDLE);
        LK_TWO:  nxt = hit[2] ? LK_OPEN : (hit[0] ? LK_ONE : LK_IDLE);
        LK_OPEN: nxt = LK_OPEN;
        default: nxt = LK_IDLE;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/lock_step_match.sv
module lock_step_match #(
  parameter int               NUM_W   = 6,
  parameter logic             REF_DIR = 1'b0,
  parameter logic [NUM_W-1:0] REF_NUM = '0
) (
  input  logic             op_dir,
  input  logic [NUM_W-1:0] op_num,
  output logic             hit
);

  function automatic logic same_op(input logic d, input logic [NUM_W-1:0] n);
    return (d == REF_DIR) && (n == REF_NUM);
  endfunction

  assign hit = same_op(op_dir, op_num);

endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
(
  input  lock_state_e cur,
  input  logic        op_valid,
  input  logic        relock,
  input  logic [2:0]  hit,
  output lock_state_e nxt
);

  always_comb begin
    nxt = lock_advance(cur, op_valid, relock, hit);
  end

endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
  import lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_state_e nxt,
  output lock_state_e cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= LK_IDLE;
    else     cur <= nxt;
  end

endmodule

// File: rtl/combo_lock_top.sv
module combo_lock_top
  import lock_pkg::*;
#(
  parameter int NUM_W     = 6,
  parameter bit STEP0_DIR = 1'b0,
  parameter int STEP0_NUM = 13,
  parameter bit STEP1_DIR = 1'b1,
  parameter int STEP1_NUM = 22,
  parameter bit STEP2_DIR = 1'b0,
  parameter int STEP2_NUM = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             relock,
  input  logic             op_valid,
  input  logic             op_dir,
  input  logic [NUM_W-1:0] op_num,
  output logic [1:0]       progress,
  output logic             unlocked
);

  localparam int NSTEP = 3;
  localparam logic [NUM_W-1:0] N0 = NUM_W'(STEP0_NUM);
  localparam logic [NUM_W-1:0] N1 = NUM_W'(STEP1_NUM);
  localparam logic [NUM_W-1:0] N2 = NUM_W'(STEP2_NUM);
  localparam logic [NSTEP*NUM_W-1:0] STEP_NUMS = {N2, N1, N0};
  localparam logic [NSTEP-1:0]       STEP_DIRS = {STEP2_DIR, STEP1_DIR, STEP0_DIR};

  logic [NSTEP-1:0] step_hit;
  lock_state_e      cur_st;
  lock_state_e      nxt_st;

  for (genvar k = 0; k < NSTEP; k++) begin : g_step
    lock_step_match #(
      .NUM_W  (NUM_W),
      .REF_DIR(STEP_DIRS[k]),
      .REF_NUM(STEP_NUMS[k*NUM_W +: NUM_W])
    ) u_match (
      .op_dir(op_dir),
      .op_num(op_num),
      .hit   (step_hit[k])
    );
  end

  lock_next_state u_next (
    .cur     (cur_st),
    .op_valid(op_valid),
    .relock  (relock),
    .hit     (step_hit),
    .nxt     (nxt_st)
  );

  lock_state_reg u_reg (
    .clk(clk),
    .rst(rst),
    .nxt(nxt_st),
    .cur(cur_st)
  );

  assign progress = cur_st;
  assign unlocked = (cur_st == LK_OPEN);

endmodule

// File: rtl/lock_checker.sv
module lock_checker (
  input logic       clk,
  input logic       rst,
  input logic       relock,
  input logic       op_valid,
  input logic [2:0] step_hit,
  input logic [1:0] progress,
  input logic       unlocked
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (progress == 2'b00 && !unlocked)); // R1
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !relock) |=> ($stable(progress) && $stable(unlocked))); // R2
  AST_OPEN_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> ($past(progress) == 2'b10 && $past(op_valid) && $past(step_hit[2]))); // R4
  AST_MISS_DROPS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !relock && progress != 2'b11 && step_hit == 3'b000) |=> progress == 2'b00); // R5
  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (unlocked && !relock) |=> unlocked); // R7
  AST_RELOCK_IDLE: assert property (@(posedge clk) disable iff (rst)
    relock |=> (progress == 2'b00)); // R8
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    (progress == 2'b10 && op_valid && !relock && step_hit[2]) |=> unlocked); // R9

endmodule

bind combo_lock_top lock_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .relock  (relock),
  .op_valid(op_valid),
  .step_hit(step_hit),
  .progress(progress),
  .unlocked(unlocked)
);

// File: tb/sim_combo_lock_top.sv
`timescale 1ns/1ps
module sim_combo_lock_top;

  logic       clk = 1'b0;
  logic       rst, relock, op_valid, op_dir;
  logic [5:0] op_num;
  logic [1:0] progress;
  logic       unlocked;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  combo_lock_top u0 (
    .clk(clk), .rst(rst), .relock(relock), .op_valid(op_valid),
    .op_dir(op_dir), .op_num(op_num), .progress(progress), .unlocked(unlocked)
  );

  // {rst, relock, valid, dir, num[5:0], expected progress[1:0], requirement[3:0]}
  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b0,1'b1,1'b0,6'd13,2'd1,4'd3},  // R3 right-13 from idle
    {1'b0,1'b0,1'b0,1'b1,6'd22,2'd1,4'd2},  // R2 no strobe
    {1'b0,1'b0,1'b1,1'b1,6'd22,2'd2,4'd3},  // R3 left-22
    {1'b0,1'b0,1'b1,1'b0,6'd3, 2'd3,4'd4},  // R4 right-3 opens
    {1'b0,1'b0,1'b1,1'b0,6'd13,2'd3,4'd7},  // R7 stays open
    {1'b0,1'b0,1'b1,1'b1,6'd5, 2'd3,4'd7},  // R7 stays open
    {1'b0,1'b1,1'b0,1'b0,6'd0, 2'd0,4'd8},  // R8 relock
    {1'b0,1'b0,1'b1,1'b1,6'd13,2'd0,4'd10}, // R10 left-13 not a first step
    {1'b0,1'b0,1'b1,1'b0,6'd13,2'd1,4'd3},  // R3
    {1'b0,1'b0,1'b1,1'b0,6'd3, 2'd0,4'd5},  // R5 wrong in 01
    {1'b0,1'b0,1'b1,1'b0,6'd13,2'd1,4'd3},  // R3
    {1'b0,1'b0,1'b1,1'b0,6'd13,2'd1,4'd5},  // R5 repeat of first step keeps 01
    {1'b0,1'b0,1'b1,1'b1,6'd22,2'd2,4'd3},  // R3
    {1'b0,1'b0,1'b1,1'b0,6'd13,2'd1,4'd5},  // R5 first step in 10 gives 01
    {1'b0,1'b0,1'b1,1'b1,6'd22,2'd2,4'd3},  // R3
    {1'b0,1'b0,1'b1,1'b1,6'd3, 2'd0,4'd10}, // R10 left-3 in 10
    {1'b0,1'b0,1'b1,1'b1,6'd22,2'd0,4'd6},  // R6 order 22,13,3
    {1'b0,1'b0,1'b1,1'b0,6'd13,2'd1,4'd6},  // R6
    {1'b0,1'b0,1'b1,1'b0,6'd3, 2'd0,4'd6},  // R6 not open
    {1'b0,1'b0,1'b1,1'b0,6'd3, 2'd0,4'd6},  // R6 order 3,13,22 start
    {1'b0,1'b0,1'b1,1'b0,6'd13,2'd1,4'd6},  // R6
    {1'b0,1'b0,1'b1,1'b1,6'd22,2'd2,4'd6},  // R6 only 10, not 11
    {1'b0,1'b0,1'b0,1'b0,6'd3, 2'd2,4'd2},  // R2 number without strobe
    {1'b0,1'b0,1'b1,1'b0,6'd3, 2'd3,4'd4},  // R4
    {1'b0,1'b1,1'b1,1'b0,6'd13,2'd0,4'd8},  // R8 relock beats valid
    {1'b1,1'b0,1'b1,1'b0,6'd13,2'd0,4'd1}   // R1 reset beats valid
  };

  task automatic check(input int req, input logic [1:0] exp);
    checks++;
    if (progress !== exp) begin
      errors++;
      $display("FAIL R%0d progress actual=%b expected=%b", req, progress, exp);
    end
    checks++;
    if (unlocked !== (exp == 2'b11)) begin // R9
      errors++;
      $display("FAIL R%0d unlocked actual=%b expected=%b", req, unlocked, exp == 2'b11);
    end
  endtask

  task automatic apply(input logic r, input logic rl, input logic v,
                       input logic d, input logic [5:0] n);
    @(negedge clk);
    rst = r; relock = rl; op_valid = v; op_dir = d; op_num = n;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0; relock = 1'b0; op_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; relock = 1'b0; op_valid = 1'b0; op_dir = 1'b0; op_num = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, 2'b00);                       // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:6]);
      check(int'(VEC[i][3:0]), VEC[i][5:4]);
    end
    // R1: reset from the open code
    apply(1'b0,1'b0,1'b1,1'b0,6'd13);
    apply(1'b0,1'b0,1'b1,1'b1,6'd22);
    apply(1'b0,1'b0,1'b1,1'b0,6'd3);
    check(4, 2'b11);
    apply(1'b1,1'b0,1'b0,1'b0,6'd0);
    check(1, 2'b00);
    // R2: long quiet period with changing bus
    apply(1'b0,1'b0,1'b1,1'b0,6'd13);
    for (int j = 0; j < 5; j++) apply(1'b0,1'b0,1'b0,1'b1,6'(22 + j));
    check(2, 2'b01);
    // R8: relock from 01
    apply(1'b0,1'b1,1'b0,1'b0,6'd0);
    check(8, 2'b00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule